// File: doc/BRIEF.md
# Host Interrupt Combiner

This block merges two interrupt lines from the local side and one software-requested interrupt into a single active-low interrupt line on the host bus. The host programs one interrupt control/status register through a simple read/write port. The port carries an address, write data, byte strobes and combinational read data.

Each local source has three fields in that register. An enable bit decides whether the source may raise the host line. A polarity bit selects active-high or active-low. A read-only status bit shows whether the source is active now.

A master enable gates everything, including the software request. The local lines come from another clock domain. Each one is resynchronised by a two-flop chain before its status and its contribution to the output are computed.

The output comes from a two-state machine with the states IRQ_IDLE and IRQ_ACTIVE. Let `req` be the master enable ANDed with the OR of the software bit and every enabled, active source. The machine has four named transitions:

- RAISE: IRQ_IDLE to IRQ_ACTIVE when `req` is 1.
- WAIT: IRQ_IDLE stays in IRQ_IDLE when `req` is 0.
- HOLD: IRQ_ACTIVE stays in IRQ_ACTIVE when `req` is 1.
- DROP: IRQ_ACTIVE to IRQ_IDLE when `req` is 0.

`irq_n` is low exactly while the machine is in IRQ_ACTIVE.

Top module: `irqgen_top`

## Requirements
- R1: After reset, with both local inputs held high, the register reads 0x00000000 and `irq_n` is high.
- R2: While the master enable (register bit 6) is 0, `irq_n` stays high, whatever the software bit and the local sources do.
- R3: When a write sets the software bit (bit 7) with bit 6 already set or set in the same write, `irq_n` goes low one clock after the write edge. When a write clears bit 7, `irq_n` returns high one clock after the write edge, provided no enabled local source is active.
- R4: When a write clears the master enable, `irq_n` returns high one clock after the write edge.
- R5: Local source 1 (`lint_in[0]`) has its enable at bit 0 and its polarity at bit 1 (1 means active-high, 0 means active-low). When it is enabled, a change on its input reaches `irq_n` on the third rising edge after the change.
- R6: Local source 2 (`lint_in[1]`) has its enable at bit 3 and its polarity at bit 4, and it behaves like source 1.
- R7: Status bits 2 (source 1) and 5 (source 2) read 1 when the synchronised input equals its active level. They change two rising edges after the input does, independent of the enable bits. Writes to the status bits are ignored.
- R8: A write has no effect in either of two cases: its address is not the register address (0), or byte strobe 0 is low. Reads at other addresses return 0. Bits 31:8 of the register always read 0.
- R9: A local source whose enable bit is 0 never drives `irq_n` low, even when the source is active and the master enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (4) | Register address; the control/status register sits at 0 |
| wdata | input | DATA_W (32) | Write data |
| be | input | DATA_W/8 (4) | Byte strobes; only lane 0 holds register bits |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |
| lint_in | input | 2 | Local interrupt inputs; bit 0 is source 1, bit 1 is source 2 |
| irq_n | output | 1 | Active-low host interrupt |

## Verification
The assertions check on every cycle that:
- `irq_n` is never low unless the master enable was set on the previous cycle;
- a set master enable together with the software bit, or with any enabled and active source, always yields a low line one cycle later;
- a fall of the master enable is followed by a high line;
- writes with byte strobe 0 low leave the control fields untouched.

Only the bench scenarios can show the rest:
- the three-edge latency from a local input pin to `irq_n`;
- the polarity encodings as seen at the ports;
- the two-edge status latency;
- the read-back layout;
- that status bits and other addresses ignore writes.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;
    localparam int BIT_EN1  = 0;
    localparam int BIT_POL1 = 1;
    localparam int BIT_ST1  = 2;
    localparam int BIT_EN2  = 3;
    localparam int BIT_POL2 = 4;
    localparam int BIT_ST2  = 5;
    localparam int BIT_MEN  = 6;
    localparam int BIT_SW   = 7;
    localparam int NUM_SRC  = 2;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;
endpackage

// File: rtl/irqgen_sync.sv
module irqgen_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q[s] <= '0;
                end else if (s == 0) begin
                    pipe_q[s] <= async_in;
                end else begin
                    pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = pipe_q[STAGES-1];
endmodule

// File: rtl/irqgen_csr.sv
module irqgen_csr
    import irqgen_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int CSR_ADDR = 0,
    localparam int BE_W    = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [BE_W-1:0]    be,
    input  logic [NUM_SRC-1:0] src_sync,
    output logic [DATA_W-1:0]  rdata,
    output logic               master,
    output logic               sw,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] pol,
    output logic [NUM_SRC-1:0] act
);
    logic       hit;
    logic       lane0_wr;
    logic [7:0] rd_byte;
    logic       unused_lanes;

    assign hit          = (addr == ADDR_W'(CSR_ADDR));
    assign lane0_wr     = wr_en && hit && be[0];
    assign unused_lanes = ^{wdata[DATA_W-1:8], be[BE_W-1:1], wdata[BIT_ST1], wdata[BIT_ST2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master <= 1'b0;
            sw     <= 1'b0;
            en     <= '0;
            pol    <= '0;
        end else if (lane0_wr) begin
            master <= wdata[BIT_MEN];
            sw     <= wdata[BIT_SW];
            en     <= {wdata[BIT_EN2],  wdata[BIT_EN1]};
            pol    <= {wdata[BIT_POL2], wdata[BIT_POL1]};
        end
    end

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_act
            assign act[i] = pol[i] ? src_sync[i] : ~src_sync[i];
        end
    endgenerate

    always_comb begin
        rd_byte           = '0;
        rd_byte[BIT_EN1]  = en[0];
        rd_byte[BIT_POL1] = pol[0];
        rd_byte[BIT_ST1]  = act[0];
        rd_byte[BIT_EN2]  = en[1];
        rd_byte[BIT_POL2] = pol[1];
        rd_byte[BIT_ST2]  = act[1];
        rd_byte[BIT_MEN]  = master;
        rd_byte[BIT_SW]   = sw;
        rdata = hit ? {{(DATA_W-8){1'b0}}, rd_byte} : '0;
    end
endmodule

// File: rtl/irqgen_fsm.sv
module irqgen_fsm
    import irqgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master,
    input  logic               sw,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] act,
    output logic               irq_n
);
    irq_state_t state_q, state_d;
    logic       req;

    assign req = master & (sw | (|(en & act)));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   state_d = req ? IRQ_ACTIVE : IRQ_IDLE;   // RAISE / WAIT
            IRQ_ACTIVE: state_d = req ? IRQ_ACTIVE : IRQ_IDLE;   // HOLD / DROP
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != IRQ_ACTIVE);
    end
endmodule

// File: rtl/irqgen_top.sv
module irqgen_top
    import irqgen_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int CSR_ADDR    = 0,
    parameter int SYNC_STAGES = 2,
    localparam int BE_W       = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [BE_W-1:0]    be,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] lint_in,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] src_sync;
    logic               ctl_master;
    logic               ctl_sw;
    logic [NUM_SRC-1:0] ctl_en;
    logic [NUM_SRC-1:0] ctl_pol;
    logic [NUM_SRC-1:0] src_act;

    irqgen_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lint_in),
        .sync_out (src_sync)
    );

    irqgen_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_ADDR(CSR_ADDR)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .be       (be),
        .src_sync (src_sync),
        .rdata    (rdata),
        .master   (ctl_master),
        .sw       (ctl_sw),
        .en       (ctl_en),
        .pol      (ctl_pol),
        .act      (src_act)
    );

    irqgen_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .master (ctl_master),
        .sw     (ctl_sw),
        .en     (ctl_en),
        .act    (src_act),
        .irq_n  (irq_n)
    );
endmodule

// File: rtl/irqgen_chk.sv
module irqgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_n,
    input logic       master,
    input logic       sw,
    input logic [1:0] en,
    input logic [1:0] pol,
    input logic [1:0] act,
    input logic       wr_en,
    input logic       be0
);
    // R2
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(master));

    // R3
    sw_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && sw) |=> !irq_n);

    // R4
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master) |=> irq_n);

    // R5
    src1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && en[0] && act[0]) |=> !irq_n);

    // R6
    src2_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && en[1] && act[1]) |=> !irq_n);

    // R8
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be0) |=> $stable({master, sw, en, pol}));
endmodule

bind irqgen_top irqgen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_n  (irq_n),
    .master (ctl_master),
    .sw     (ctl_sw),
    .en     (ctl_en),
    .pol    (ctl_pol),
    .act    (src_act),
    .wr_en  (wr_en),
    .be0    (be[0])
);

// File: tb/irqgen_top_bench.sv
`timescale 1ns/1ps
module irqgen_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic [1:0]  lint_in = 2'b11;
    logic        irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqgen_top u_irqgen_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .be(be), .rdata(rdata), .lint_in(lint_in), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expect_v);
        checks++;
        if (actual !== expect_v) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, actual, expect_v, $time);
        end
    endtask

    // Drives at a falling edge, writes on the next rising edge, returns at the following falling edge
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0; be = '0;
    endtask

    task automatic wr(input logic [7:0] v);
        bus_wr(4'd0, {24'd0, v}, 4'b0001);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        idle(4);
        chk("R1 csr after reset", rdata, 32'h0);
        chk("R1 irq_n after reset", {31'd0, irq_n}, 32'd1);
    endtask

    task automatic t_master_gate();
        wr(8'h9B);
        idle(4);
        chk("R2 sw and sources without master", {31'd0, irq_n}, 32'd1);
        lint_in = 2'b00;
        idle(4);
        chk("R2 active sources without master", {31'd0, irq_n}, 32'd1);
        lint_in = 2'b11;
        wr(8'h00);
        idle(3);
    endtask

    task automatic t_sw();
        wr(8'hC0);
        chk("R3 not yet low", {31'd0, irq_n}, 32'd1);
        @(negedge clk);
        chk("R3 sw asserts", {31'd0, irq_n}, 32'd0);
        chk("R3 readback", rdata, 32'hC0);
        wr(8'h40);
        chk("R3 still low", {31'd0, irq_n}, 32'd0);
        @(negedge clk);
        chk("R3 sw clear releases", {31'd0, irq_n}, 32'd1);
    endtask

    task automatic t_master_clear();
        wr(8'hC0);
        idle(2);
        wr(8'h80);
        @(negedge clk);
        chk("R4 master clear releases", {31'd0, irq_n}, 32'd1);
        wr(8'h00);
    endtask

    task automatic t_src1();
        wr(8'h41);
        lint_in[0] = 1'b0;
        idle(2);
        chk("R5 low-active before 3rd edge", {31'd0, irq_n}, 32'd1);
        @(negedge clk);
        chk("R5 low-active asserts", {31'd0, irq_n}, 32'd0);
        lint_in[0] = 1'b1;
        idle(2);
        chk("R5 still low", {31'd0, irq_n}, 32'd0);
        @(negedge clk);
        chk("R5 releases", {31'd0, irq_n}, 32'd1);
        wr(8'h43);
        @(negedge clk);
        chk("R5 high-active asserts", {31'd0, irq_n}, 32'd0);
        lint_in[0] = 1'b0;
        idle(3);
        chk("R5 high-active releases", {31'd0, irq_n}, 32'd1);
        lint_in[0] = 1'b1;
        wr(8'h00);
        idle(3);
    endtask

    task automatic t_src2();
        wr(8'h48);
        lint_in[1] = 1'b0;
        idle(2);
        chk("R6 before 3rd edge", {31'd0, irq_n}, 32'd1);
        @(negedge clk);
        chk("R6 low-active asserts", {31'd0, irq_n}, 32'd0);
        lint_in[1] = 1'b1;
        idle(3);
        chk("R6 releases", {31'd0, irq_n}, 32'd1);
        wr(8'h58);
        @(negedge clk);
        chk("R6 high-active asserts", {31'd0, irq_n}, 32'd0);
        wr(8'h00);
        idle(2);
    endtask

    task automatic t_status();
        chk("R7 status idle", rdata, 32'h0);
        lint_in[0] = 1'b0;
        @(negedge clk);
        chk("R7 status after one edge", rdata, 32'h0);
        @(negedge clk);
        chk("R7 status src1 active", rdata, 32'h04);
        wr(8'h24);
        chk("R7 status write ignored", rdata, 32'h04);
        wr(8'h10);
        idle(2);
        chk("R7 src2 high-active status", rdata, 32'h34);
        wr(8'h40);
        idle(3);
        chk("R9 disabled active source", {31'd0, irq_n}, 32'd1);
        lint_in[0] = 1'b1;
        wr(8'h00);
        idle(3);
    endtask

    task automatic t_strobe();
        bus_wr(4'd0, 32'h0000_00C0, 4'b1110);
        idle(2);
        chk("R8 lane0 strobe low no write", rdata, 32'h0);
        chk("R8 lane0 strobe low irq", {31'd0, irq_n}, 32'd1);
        bus_wr(4'd1, 32'h0000_00C0, 4'b0001);
        idle(2);
        chk("R8 other address no write", {31'd0, irq_n}, 32'd1);
        bus_wr(4'd0, 32'hFFFF_FF41, 4'b1111);
        chk("R8 upper bits read zero", rdata, 32'h41);
        @(negedge clk);
        addr = 4'd1;
        #1;
        chk("R8 other address reads zero", rdata, 32'h0);
        addr = 4'd0;
        wr(8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_master_gate();
        t_sw();
        t_master_clear();
        t_src1();
        t_src2();
        t_status();
        t_strobe();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule